// File: doc/BRIEF.md
# Serial Digital Potentiometer Command Engine

This block is the digital side of a two-channel digital potentiometer that a host drives over a synchronous serial link. While the select line is low, the host clocks in one command word MSB first. The word is 24 bits: a 4-bit opcode in bits 23..20, a 4-bit address in bits 19..16 and a 16-bit data field in bits 15..0. The word is decoded and carried out only when select returns high, and only if exactly 24 bits arrived during that frame.

The engine holds two 10-bit wiper registers and a 16-entry bank of 16-bit retained registers. The retained bank is built from flip-flops. Entries 0 and 1 back the two wipers and the other fourteen entries are free storage. The commands cover:
- direct wiper writes;
- saturating step up and step down, on one wiper or on both;
- saturating doubling and halving, on one wiper or on both;
- save and restore between the wipers and the retained bank;
- raw writes to the retained bank;
- readback.

The serial output normally repeats the previous 24 bits shifted in, so several devices can be daisy-chained. After a read command, the next frame returns the selected value in place of the data field. A restore pin, a write-protect pin and a busy indication complete the interface.

Top module: `dpot_cmd_engine`

## Requirements
- R1: After reset both wipers read 0x200, `ready` is 1, `prog_read` is 0 and `ser_dout` is 0. Retained entries 0 and 1 hold 0x0200 and all other entries hold 0.
- R2: A frame is carried out only on the rising edge of `ser_sel_n`, and only if exactly 24 rising edges of `ser_clk` occurred while select was low. A frame with any other bit count has no effect, and while bits are still being shifted no wiper changes.
- R3: Opcode 11 loads data bits 9..0 into wiper(A0), where A0 is word bit 16.
- R4: Opcodes 14 and 15 add one to wiper(A0) or to both wipers, holding at 0x3FF. Opcodes 6 and 7 subtract one from wiper(A0) or from both wipers, holding at 0. All four ignore the data field.
- R5: Opcodes 12 and 13 double wiper(A0) or both wipers, giving 0x3FF whenever bit 9 was already set (0x200 becomes 0x3FF). Opcodes 4 and 5 halve wiper(A0) or both wipers by a right shift.
- R6: Opcode 3 writes the 16 data bits to retained entry(address bits 19..16). Opcode 2 copies wiper(A0), zero-extended, into entry(A0). Opcode 9 reads entry(address).
- R7: Opcode 1 copies the low 10 bits of entry(A0) into wiper(A0) and sets `prog_read`. Opcode 0 clears `prog_read`.
- R8: After an executed opcode 9 or 10, the next frame shifts out bits 23..16 of the last 24 bits received, followed by the selected 16-bit value. Opcode 10 returns wiper(A0) zero-extended.
- R9: Otherwise `ser_dout` shifts out, MSB first, the last 24 bits received before the current frame began.
- R10: While `protect_n` is 0, opcodes 2 and 3 leave the retained bank unchanged and do not drop `ready`.
- R11: A retained write holds `ready` low for NV_BUSY_CYC clock cycles, and a frame that ends while `ready` is low is ignored.
- R12: A falling edge on `restore_n` reloads wiper 0 and wiper 1 from the low 10 bits of entries 0 and 1.
- R13: Opcode 8 reloads both wipers from the low 10 bits of entries 0 and 1, ignoring bits 15..10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial inputs are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data in, MSB first |
| ser_dout | output | 1 | Serial data out for daisy-chaining and readback |
| restore_n | input | 1 | Falling edge reloads both wipers from retained entries 0 and 1 |
| protect_n | input | 1 | Low blocks all writes to the retained bank |
| ready | output | 1 | Low while a retained write is in progress |
| prog_read | output | 1 | Set by opcode 1, cleared by opcode 0 |
| wiper0 | output | 10 | Wiper register of channel 0 |
| wiper1 | output | 10 | Wiper register of channel 1 |

## Verification
The embedded assertions check several properties on every cycle:
- wipers stay constant except after an executed frame or a restore strobe;
- a wiper at full scale stays there under step-up and doubling;
- a retained write never occurs while protection is asserted and is always followed by `ready` low;
- the bit counter and serial output stay frozen between frames;
- `prog_read` only rises after an executed opcode 1.

Only the bench scenarios can show the rest:
- the exact bits returned by daisy-chain and readback frames;
- that truncated frames and frames sent while busy change nothing;
- the precise length of the busy window;
- that random mixes of all sixteen opcodes match an independent reference model.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  localparam int CMD_W  = 4;
  localparam int AFLD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP      = 4'd0,
    CMD_NV2W     = 4'd1,
    CMD_W2NV     = 4'd2,
    CMD_NVWR     = 4'd3,
    CMD_HALF_ONE = 4'd4,
    CMD_HALF_ALL = 4'd5,
    CMD_DEC_ONE  = 4'd6,
    CMD_DEC_ALL  = 4'd7,
    CMD_RELOAD   = 4'd8,
    CMD_NVRD     = 4'd9,
    CMD_WRD      = 4'd10,
    CMD_WWR      = 4'd11,
    CMD_DBL_ONE  = 4'd12,
    CMD_DBL_ALL  = 4'd13,
    CMD_INC_ONE  = 4'd14,
    CMD_INC_ALL  = 4'd15
  } cmd_e;

  typedef enum logic [2:0] {
    WOP_HOLD,
    WOP_LOAD,
    WOP_INC,
    WOP_DEC,
    WOP_DBL,
    WOP_HALF
  } wop_e;

endpackage

// File: rtl/dpot_serial_rx.sv
module dpot_serial_rx #(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_sel_n,
  input  logic                 ser_din,
  input  logic                 rb_pend,
  input  logic [DATA_W-1:0]    rb_data,
  output logic                 frame_start,
  output logic                 frame_done,
  output logic                 frame_ok,
  output logic [DATA_W+7:0]    word,
  output logic                 ser_dout
);

  localparam int WORD_W = DATA_W + 8;
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  logic              sclk_q;
  logic              sel_q;
  logic              bit_rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] in_sr;
  logic [WORD_W-1:0] out_sr;

  assign bit_rise    = ser_clk & ~sclk_q & ~ser_sel_n;
  assign frame_start = sel_q & ~ser_sel_n;
  assign frame_done  = ~sel_q & ser_sel_n;
  assign frame_ok    = (bit_cnt == CNT_FULL);
  assign word        = in_sr;
  assign ser_dout    = out_sr[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b1;
    end else begin
      sclk_q <= ser_clk;
      sel_q  <= ser_sel_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      in_sr   <= '0;
    end else if (frame_start) begin
      bit_cnt <= '0;
    end else if (bit_rise) begin
      in_sr <= {in_sr[WORD_W-2:0], ser_din};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_sr <= '0;
    end else if (frame_start) begin
      out_sr <= rb_pend ? {in_sr[WORD_W-1 -: 8], rb_data} : in_sr;
    end else if (bit_rise) begin
      out_sr <= {out_sr[WORD_W-2:0], 1'b0};
    end
  end

  // R2
  cnt_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel_n && sel_q) |=> $stable(bit_cnt));

  // R9
  dout_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel_n && sel_q) |=> $stable(ser_dout));

endmodule

// File: rtl/dpot_nv_store.sv
module dpot_nv_store #(
  parameter int          DEPTH       = 16,
  parameter int          DATA_W      = 16,
  parameter int          WW          = 10,
  parameter int unsigned WIPER_RESET = 512
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [$clog2(DEPTH)-1:0]  waddr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      wp_release,
  input  logic [$clog2(DEPTH)-1:0]  rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [WW-1:0]             ent0,
  output logic [WW-1:0]             ent1
);

  localparam logic [DATA_W-1:0] WIPE_INIT = DATA_W'(WIPER_RESET);

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[e] <= (e < 2) ? WIPE_INIT : '0;
      end else if (we && (waddr == e)) begin
        mem[e] <= wdata;
      end
    end
  end

  assign rd_data = mem[rd_addr];
  assign ent0    = mem[0][WW-1:0];
  assign ent1    = mem[1][WW-1:0];

  // R10
  nv_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> wp_release);

endmodule

// File: rtl/dpot_wiper_bank.sv
module dpot_wiper_bank
  import dpot_pkg::*;
#(
  parameter int          WW          = 10,
  parameter int unsigned WIPER_RESET = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wop_e                op,
  input  logic [1:0]          mask,
  input  logic [WW-1:0]       ld0,
  input  logic [WW-1:0]       ld1,
  output logic [1:0][WW-1:0]  q
);

  localparam logic [WW-1:0] TOP  = '1;
  localparam logic [WW-1:0] INIT = WW'(WIPER_RESET);

  function automatic logic [WW-1:0] f_inc(input logic [WW-1:0] v);
    return (v == TOP) ? TOP : v + 1'b1;
  endfunction

  function automatic logic [WW-1:0] f_dec(input logic [WW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [WW-1:0] f_dbl(input logic [WW-1:0] v);
    return v[WW-1] ? TOP : {v[WW-2:0], 1'b0};
  endfunction

  function automatic logic [WW-1:0] f_half(input logic [WW-1:0] v);
    return {1'b0, v[WW-1:1]};
  endfunction

  logic [1:0][WW-1:0] ld;
  assign ld[0] = ld0;
  assign ld[1] = ld1;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [WW-1:0] nxt;

    always_comb begin
      unique case (op)
        WOP_LOAD: nxt = ld[c];
        WOP_INC:  nxt = f_inc(q[c]);
        WOP_DEC:  nxt = f_dec(q[c]);
        WOP_DBL:  nxt = f_dbl(q[c]);
        WOP_HALF: nxt = f_half(q[c]);
        default:  nxt = q[c];
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       q[c] <= INIT;
      else if (mask[c]) q[c] <= nxt;
    end

    // R4
    inc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == WOP_INC && mask[c] && q[c] == TOP) |=> (q[c] == TOP));

    // R5
    dbl_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == WOP_DBL && mask[c] && q[c][WW-1]) |=> (q[c] == TOP));
  end

endmodule

// File: rtl/dpot_cmd_engine.sv
module dpot_cmd_engine
  import dpot_pkg::*;
#(
  parameter int          WIPER_W     = 10,
  parameter int          NV_W        = 16,
  parameter int          NV_DEPTH    = 16,
  parameter int          NV_BUSY_CYC = 200,
  parameter int unsigned WIPER_RESET = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_sel_n,
  input  logic               ser_din,
  output logic               ser_dout,
  input  logic               restore_n,
  input  logic               protect_n,
  output logic               ready,
  output logic               prog_read,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1
);

  localparam int WORD_W = NV_W + 8;
  localparam int ADDR_W = $clog2(NV_DEPTH);
  localparam int BUSY_W = $clog2(NV_BUSY_CYC + 2);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(NV_BUSY_CYC);

  // serial front end
  logic              frame_start, frame_done, frame_ok;
  logic [WORD_W-1:0] word;
  logic              rb_pend;
  logic [NV_W-1:0]   rb_data;

  dpot_serial_rx #(.DATA_W(NV_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk     (ser_clk),
    .ser_sel_n   (ser_sel_n),
    .ser_din     (ser_din),
    .rb_pend     (rb_pend),
    .rb_data     (rb_data),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .frame_ok    (frame_ok),
    .word        (word),
    .ser_dout    (ser_dout)
  );

  // field decode
  cmd_e              cmd;
  logic [AFLD_W-1:0] addr_f;
  logic              a0;
  logic [NV_W-1:0]   data_f;

  assign cmd    = cmd_e'(word[WORD_W-1 -: CMD_W]);
  assign addr_f = word[NV_W +: AFLD_W];
  assign a0     = addr_f[0];
  assign data_f = word[NV_W-1:0];

  // events brought out as named wires
  logic exec_fire;
  logic restore_fire;
  logic rest_q;
  logic [BUSY_W-1:0] busy_cnt;

  assign ready        = (busy_cnt == '0);
  assign exec_fire    = frame_done & frame_ok & ready;
  assign restore_fire = rest_q & ~restore_n;

  always_ff @(posedge clk) begin
    if (!rst_n) rest_q <= 1'b1;
    else        rest_q <= restore_n;
  end

  // wiper storage
  logic [1:0][WIPER_W-1:0] wq;
  logic [WIPER_W-1:0]      wsel;

  assign wiper0 = wq[0];
  assign wiper1 = wq[1];
  assign wsel   = a0 ? wq[1] : wq[0];

  // retained storage
  logic              nv_we;
  logic [ADDR_W-1:0] nv_waddr, nv_raddr;
  logic [NV_W-1:0]   nv_wdata, nv_rdata;
  logic [WIPER_W-1:0] nv_e0, nv_e1;
  logic              is_nv_write;

  assign is_nv_write = (cmd == CMD_W2NV) || (cmd == CMD_NVWR);
  assign nv_we    = exec_fire & protect_n & is_nv_write;
  assign nv_waddr = (cmd == CMD_NVWR) ? addr_f[ADDR_W-1:0] : ADDR_W'(a0);
  assign nv_wdata = (cmd == CMD_NVWR) ? data_f
                                      : {{(NV_W-WIPER_W){1'b0}}, wsel};
  assign nv_raddr = (cmd == CMD_NVRD) ? addr_f[ADDR_W-1:0] : ADDR_W'(a0);

  dpot_nv_store #(
    .DEPTH       (NV_DEPTH),
    .DATA_W      (NV_W),
    .WW          (WIPER_W),
    .WIPER_RESET (WIPER_RESET)
  ) u_nv (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (nv_we),
    .waddr      (nv_waddr),
    .wdata      (nv_wdata),
    .wp_release (protect_n),
    .rd_addr    (nv_raddr),
    .rd_data    (nv_rdata),
    .ent0       (nv_e0),
    .ent1       (nv_e1)
  );

  // wiper operation select
  wop_e               w_op;
  logic [1:0]         w_mask;
  logic [1:0]         one_mask;
  logic [WIPER_W-1:0] w_ld0, w_ld1;

  assign one_mask = a0 ? 2'b10 : 2'b01;

  always_comb begin
    w_op   = WOP_HOLD;
    w_mask = 2'b00;
    w_ld0  = nv_e0;
    w_ld1  = nv_e1;
    if (restore_fire) begin
      w_op   = WOP_LOAD;
      w_mask = 2'b11;
    end else if (exec_fire) begin
      unique case (cmd)
        CMD_NV2W: begin
          w_op = WOP_LOAD; w_mask = one_mask;
          w_ld0 = nv_rdata[WIPER_W-1:0]; w_ld1 = nv_rdata[WIPER_W-1:0];
        end
        CMD_WWR: begin
          w_op = WOP_LOAD; w_mask = one_mask;
          w_ld0 = data_f[WIPER_W-1:0]; w_ld1 = data_f[WIPER_W-1:0];
        end
        CMD_RELOAD:   begin w_op = WOP_LOAD; w_mask = 2'b11;    end
        CMD_HALF_ONE: begin w_op = WOP_HALF; w_mask = one_mask; end
        CMD_HALF_ALL: begin w_op = WOP_HALF; w_mask = 2'b11;    end
        CMD_DEC_ONE:  begin w_op = WOP_DEC;  w_mask = one_mask; end
        CMD_DEC_ALL:  begin w_op = WOP_DEC;  w_mask = 2'b11;    end
        CMD_DBL_ONE:  begin w_op = WOP_DBL;  w_mask = one_mask; end
        CMD_DBL_ALL:  begin w_op = WOP_DBL;  w_mask = 2'b11;    end
        CMD_INC_ONE:  begin w_op = WOP_INC;  w_mask = one_mask; end
        CMD_INC_ALL:  begin w_op = WOP_INC;  w_mask = 2'b11;    end
        default:      begin w_op = WOP_HOLD; w_mask = 2'b00;    end
      endcase
    end
  end

  dpot_wiper_bank #(
    .WW          (WIPER_W),
    .WIPER_RESET (WIPER_RESET)
  ) u_wip (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (w_op),
    .mask  (w_mask),
    .ld0   (w_ld0),
    .ld1   (w_ld1),
    .q     (wq)
  );

  // busy window, status flag, readback latch
  always_ff @(posedge clk) begin
    if (!rst_n)              busy_cnt <= '0;
    else if (nv_we)          busy_cnt <= BUSY_LOAD;
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_read <= 1'b0;
    end else if (exec_fire) begin
      if (cmd == CMD_NV2W)     prog_read <= 1'b1;
      else if (cmd == CMD_NOP) prog_read <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_pend <= 1'b0;
      rb_data <= '0;
    end else if (exec_fire && cmd == CMD_NVRD) begin
      rb_pend <= 1'b1;
      rb_data <= nv_rdata;
    end else if (exec_fire && cmd == CMD_WRD) begin
      rb_pend <= 1'b1;
      rb_data <= {{(NV_W-WIPER_W){1'b0}}, wsel};
    end else if (frame_start) begin
      rb_pend <= 1'b0;
    end
  end

  // R2
  wiper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_fire || restore_fire) |=> ($stable(wiper0) && $stable(wiper1)));

  // R11
  busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |=> !ready);

  // R7
  prog_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_read) |-> $past(exec_fire && cmd == CMD_NV2W));

endmodule

// File: tb/dpot_cmd_engine_bench.sv
module dpot_cmd_engine_bench;

  localparam int BUSY = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_sel_n = 1'b1, ser_din = 1'b0;
  logic restore_n = 1'b1, protect_n = 1'b1;
  logic ser_dout, ready, prog_read;
  logic [9:0] wiper0, wiper1;

  always #4 clk = ~clk;

  dpot_cmd_engine #(.NV_BUSY_CYC(BUSY)) u_dpot_cmd_engine (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
    .ser_din(ser_din), .ser_dout(ser_dout), .restore_n(restore_n),
    .protect_n(protect_n), .ready(ready), .prog_read(prog_read),
    .wiper0(wiper0), .wiper1(wiper1)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  logic [23:0] m_sr = '0;
  int m_nv [16];
  int m_w  [2];
  int m_prog = 0;
  bit m_rb_pend = 0;
  int m_rb = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int up1(input int v);   return (v >= 1023) ? 1023 : v + 1; endfunction
  function automatic int dn1(input int v);   return (v <= 0) ? 0 : v - 1;       endfunction
  function automatic int twice(input int v); return (v * 2 > 1023) ? 1023 : v * 2; endfunction
  function automatic int half(input int v);  return v / 2;                       endfunction

  task automatic model_exec(input logic [23:0] w);
    int c = int'(w[23:20]);
    int a = int'(w[19:16]);
    int s = int'(w[16]);
    int d = int'(w[15:0]);
    case (c)
      0:  m_prog = 0;
      1:  begin m_w[s] = m_nv[s] % 1024; m_prog = 1; end
      2:  if (protect_n) m_nv[s] = m_w[s];
      3:  if (protect_n) m_nv[a] = d;
      4:  m_w[s] = half(m_w[s]);
      5:  for (int i = 0; i < 2; i++) m_w[i] = half(m_w[i]);
      6:  m_w[s] = dn1(m_w[s]);
      7:  for (int i = 0; i < 2; i++) m_w[i] = dn1(m_w[i]);
      8:  for (int i = 0; i < 2; i++) m_w[i] = m_nv[i] % 1024;
      9:  begin m_rb_pend = 1; m_rb = m_nv[a]; end
      10: begin m_rb_pend = 1; m_rb = m_w[s]; end
      11: m_w[s] = d % 1024;
      12: m_w[s] = twice(m_w[s]);
      13: for (int i = 0; i < 2; i++) m_w[i] = twice(m_w[i]);
      14: m_w[s] = up1(m_w[s]);
      default: for (int i = 0; i < 2; i++) m_w[i] = up1(m_w[i]);
    endcase
  endtask

  task automatic check_state(input string req);
    chk(req, int'(wiper0), m_w[0]);
    chk(req, int'(wiper1), m_w[1]);
    chk(req, int'(prog_read), m_prog);
  endtask

  // one frame; ignored=1 when the bench expects the frame to land while busy
  task automatic send(input logic [23:0] w, input int nbits, input bit wait_rdy,
                      input bit ignored, input string req);
    logic [23:0] exp_out, got;
    got = '0;
    if (wait_rdy) while (!ready) @(negedge clk);
    exp_out = m_rb_pend ? {m_sr[23:16], m_rb[15:0]} : m_sr;
    m_rb_pend = 0;
    ser_sel_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      ser_din = (i < 24) ? w[23-i] : 1'b0;
      repeat (2) @(negedge clk);
      if (i < 24) got[23-i] = ser_dout;
      m_sr = {m_sr[22:0], ser_din};
      ser_clk = 1'b1;
      repeat (2) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (2) @(negedge clk);
    check_state("R2");                      // nothing acts before select rises
    ser_sel_n = 1'b1;
    repeat (3) @(negedge clk);
    if (nbits == 24) begin
      chk({req, "/R9"}, int'(got), int'(exp_out));
      if (!ignored) model_exec(w);
    end
    check_state(req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int n;
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) m_nv[i] = (i < 2) ? 'h200 : 0;
    m_w[0] = 'h200; m_w[1] = 'h200;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(wiper0), 'h200);
    chk("R1", int'(wiper1), 'h200);
    chk("R1", int'(ready), 1);
    chk("R1", int'(prog_read), 0);
    chk("R1", int'(ser_dout), 0);

    // R3 direct writes, R9 daisy-chain output
    send(24'hB00100, 24, 1, 0, "R3");
    send(24'hB10200, 24, 1, 0, "R3");
    chk("R3", int'(wiper1), 'h200);
    // R5 doubling with saturation: 0x200 -> 0x3FF
    send(24'hC1ABCD, 24, 1, 0, "R5");
    chk("R5", int'(wiper1), 'h3FF);
    send(24'h400000, 24, 1, 0, "R5");
    send(24'h500000, 24, 1, 0, "R5");
    // R4 saturation at both ends
    send(24'hB103FF, 24, 1, 0, "R4");
    send(24'hE1FFFF, 24, 1, 0, "R4");
    chk("R4", int'(wiper1), 'h3FF);
    send(24'hB00000, 24, 1, 0, "R4");
    send(24'h60FFFF, 24, 1, 0, "R4");
    chk("R4", int'(wiper0), 0);
    send(24'hF00000, 24, 1, 0, "R4");
    send(24'h700000, 24, 1, 0, "R4");

    // R8 readback of wiper: expect A1 03 FF style frame
    send(24'hB103FF, 24, 1, 0, "R8");
    send(24'hA10000, 24, 1, 0, "R8");
    send(24'h000000, 24, 1, 0, "R8");

    // R6 retained write + read, R11 busy length
    send(24'h32AAAA, 24, 1, 0, "R6");
    chk("R11", int'(ready), 0);
    n = 0;
    while (!ready) begin @(negedge clk); n++; end
    chk("R11", n, BUSY - 2);
    send(24'h920000, 24, 1, 0, "R6");
    send(24'h000000, 24, 1, 0, "R6");

    // R11 command during busy is ignored
    send(24'h335555, 24, 1, 0, "R11");
    send(24'hE00000, 24, 0, 1, "R11");
    chk("R11", int'(wiper0), m_w[0]);
    send(24'h930000, 24, 1, 0, "R11");
    send(24'h000000, 24, 1, 0, "R11");

    // R10 protected writes change nothing, no busy
    protect_n = 1'b0;
    send(24'h321234, 24, 1, 0, "R10");
    chk("R10", int'(ready), 1);
    send(24'h200000, 24, 1, 0, "R10");
    send(24'h920000, 24, 1, 0, "R10");
    send(24'h000000, 24, 1, 0, "R10");
    protect_n = 1'b1;

    // R6/R7 save, modify, restore; prog flag
    send(24'hB00155, 24, 1, 0, "R6");
    send(24'h200000, 24, 1, 0, "R6");
    send(24'hB00001, 24, 1, 0, "R7");
    send(24'h100000, 24, 1, 0, "R7");
    chk("R7", int'(wiper0), 'h155);
    chk("R7", int'(prog_read), 1);
    send(24'h000000, 24, 1, 0, "R7");
    chk("R7", int'(prog_read), 0);

    // R13 reload uses low 10 bits only
    send(24'h30FFFF, 24, 1, 0, "R13");
    send(24'h311155, 24, 1, 0, "R13");
    send(24'h800000, 24, 1, 0, "R13");
    chk("R13", int'(wiper0), 'h3FF);
    chk("R13", int'(wiper1), 'h155);

    // R12 restore pin
    send(24'hB00007, 24, 1, 0, "R12");
    send(24'hB10009, 24, 1, 0, "R12");
    restore_n = 1'b0;
    repeat (3) @(negedge clk);
    restore_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) m_w[i] = m_nv[i] % 1024;
    check_state("R12");

    // R2 wrong bit counts are discarded
    send(24'hB00123, 23, 1, 0, "R2");
    send(24'hB00123, 25, 1, 0, "R2");
    send(24'h000000, 24, 1, 0, "R2");

    // random mix of all opcodes
    for (int k = 0; k < 60; k++) begin
      logic [23:0] w;
      w = $urandom();
      if (($urandom() % 8) == 0) protect_n = ~protect_n;
      send(w, 24, 1, 0, "R6");
    end
    protect_n = 1'b1;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule